// File: doc/BRIEF.md
# MSI Doorbell Interrupt Frame

This block is a small memory-mapped register frame. It turns message-signalled interrupt writes into single-cycle pulses on a bank of shared peripheral interrupt lines. A device signals an interrupt by writing an absolute interrupt number into the doorbell register. The frame subtracts the first number of its configured window from that value. If the result falls inside the window, the frame raises the matching output line for one clock. If it falls outside, the write is dropped without any error.

Software finds the window by reading a type register. That register reports the first interrupt number and the number of lines. An identification register returns a fixed product code. A block of identification space reads as zero. Any access to an undefined offset, or with an unsupported byte count, returns an error flag with the response.

The window base and the line count are parameters. Elaboration stops on an illegal pair: more than 128 lines, or a window whose last number would pass 1020.

Top module: `msi_doorbell_frame`

## Requirements
- R1: `reqReady` goes high in the cycle after `reqValid` is first seen. A transfer takes place on the edge where `reqValid` and `reqReady` are both high. `rspValid` is high for exactly the one cycle after that edge, together with `rspRdata` and `rspErr`. `reqReady` is low in that response cycle.
- R2: A 4-byte read of offset 0x008 returns the first interrupt number, which is BASE_SPI+32, in bits [25:16] and NUM_SPI in bits [9:0]. All other bits are zero, and there is no error.
- R3: A write of size 2 or 4 to offset 0x040 takes an ID from data bits [9:0]. When the ID satisfies BASE_SPI+32 <= ID < BASE_SPI+32+NUM_SPI, line `irqOut[ID-(BASE_SPI+32)]` is high for exactly the response cycle, and every other line stays low.
- R4: A doorbell write whose ID falls below or above the window pulses no line and reports no error.
- R5: `reqSize` gives the access width in bytes. A write is legal only with a value of 2 or 4. A write with any other value pulses no line and reports an error.
- R6: A 4-byte read of offset 0xFCC returns 0x051 in bits [31:20] and zero in all lower bits, with no error.
- R7: A 4-byte read of any offset from 0xFD0 to 0xFFC inclusive returns zero with no error.
- R8: These accesses report an error, return zero read data and pulse no line: a read of the doorbell offset, a write to any offset other than 0x040, and any access to an offset not named in R2, R3, R6 or R7.
- R9: A read with `reqSize` other than 4 returns zero and reports an error, even at a defined offset.
- R10: Two consecutive doorbell writes to the same ID produce two separate pulses, with the line low for at least one cycle between them.
- R11: Data bits [31:10] of a doorbell write have no effect on which line is pulsed. This includes 2-byte writes whose upper half carries arbitrary values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request valid, held until accepted |
| reqReady | output | 1 | Request accepted on this edge when high with reqValid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 12 | Byte offset inside the frame |
| reqWdata | input | 32 | Write data, little-endian |
| reqSize | input | 3 | Access width in bytes |
| rspValid | output | 1 | One-cycle response strobe |
| rspRdata | output | 32 | Read data for the response |
| rspErr | output | 1 | Bad offset or size |
| irqOut | output | NUM_SPI | Interrupt pulse lines |

## Verification
The bench targets both window edges: the first ID, the last ID, one below the window and one past it. An off-by-one in the rebase or in the compare would fire a wrong line, or fire a line for an ID outside the window. Two doorbell writes to the same line are sent back to back. A design that held its pulse until a later cycle would merge them into one long pulse. The bench also sends bad widths, reads of the write-only doorbell and writes to read-only offsets. A decoder that ignored size or direction would fire lines or return register contents with no error flag.

// File: rtl/msi_frame_pkg.sv
package msi_frame_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int ID_W   = 10;

  localparam logic [ADDR_W-1:0] OFF_TYPE   = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_BELL   = 12'h040;
  localparam logic [ADDR_W-1:0] OFF_IDENT  = 12'hFCC;
  localparam logic [ADDR_W-1:0] OFF_ZERO_LO = 12'hFD0;
  localparam logic [ADDR_W-1:0] OFF_ZERO_HI = 12'hFFC;

  localparam logic [11:0] PRODUCT_CODE = 12'h051;

  // Strobes from control to datapath, valid in the transfer cycle
  typedef struct packed {
    logic fire;    // transfer happens this cycle
    logic ring;    // legal doorbell write
    logic rdType;  // legal type register read
    logic rdIdent; // legal identification read
    logic bad;     // offset or size error
  } frameStrobe_t;
endpackage

// File: rtl/msi_frame_ctrl.sv
module msi_frame_ctrl
  import msi_frame_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [2:0]        reqSize,
  output logic              reqReady,
  output frameStrobe_t      strb,
  output logic              rspValid,
  output logic              rspErr
);
  logic handshake;
  logic hitType, hitBell, hitIdent, hitZero;
  logic sizeOk, accessOk;

  always_comb begin
    handshake = reqValid && reqReady;
    hitType   = (reqAddr == OFF_TYPE);
    hitBell   = (reqAddr == OFF_BELL);
    hitIdent  = (reqAddr == OFF_IDENT);
    hitZero   = (reqAddr >= OFF_ZERO_LO) && (reqAddr <= OFF_ZERO_HI);
    if (reqWrite) begin
      sizeOk   = (reqSize == 3'd2) || (reqSize == 3'd4);
      accessOk = hitBell && sizeOk;
    end else begin
      sizeOk   = (reqSize == 3'd4);
      accessOk = (hitType || hitIdent || hitZero) && sizeOk;
    end
    strb.fire    = handshake;
    strb.ring    = handshake && reqWrite && accessOk;
    strb.rdType  = handshake && !reqWrite && accessOk && hitType;
    strb.rdIdent = handshake && !reqWrite && accessOk && hitIdent;
    strb.bad     = handshake && !accessOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqReady <= 1'b0;
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
    end else begin
      reqReady <= reqValid && !reqReady;
      rspValid <= handshake;
      rspErr   <= strb.bad;
    end
  end

  // R1
  ready_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |=> reqReady);
  // R1
  rsp_after_xfer_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> rspValid && !reqReady);
  // R1
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);
  // R8
  err_in_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> rspValid);
endmodule

// File: rtl/msi_frame_dp.sv
module msi_frame_dp
  import msi_frame_pkg::*;
#(
  parameter int BASE_SPI = 0,
  parameter int NUM_SPI  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  frameStrobe_t      strb,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] rspRdata,
  output logic [NUM_SPI-1:0] irqOut
);
  localparam int FIRST_ID = BASE_SPI + 32;
  localparam int END_ID   = FIRST_ID + NUM_SPI;
  localparam logic [DATA_W-1:0] TYPE_WORD =
    DATA_W'((FIRST_ID << 16) | NUM_SPI);
  localparam logic [DATA_W-1:0] IDENT_WORD = {PRODUCT_CODE, 20'h0};

  logic [ID_W-1:0]    reqId;
  int                 relIdx;
  logic               inRange;
  logic [NUM_SPI-1:0] lineHit;
  logic [DATA_W-1:0]  rdNext;

  always_comb begin
    reqId   = reqWdata[ID_W-1:0];
    relIdx  = int'(reqId) - FIRST_ID;
    inRange = (int'(reqId) >= FIRST_ID) && (int'(reqId) < END_ID);
  end

  for (genvar g = 0; g < NUM_SPI; g++) begin : g_line
    assign lineHit[g] = strb.ring && inRange && (relIdx == g);
  end

  always_comb begin
    if (strb.rdType)       rdNext = TYPE_WORD;
    else if (strb.rdIdent) rdNext = IDENT_WORD;
    else                   rdNext = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqOut   <= '0;
      rspRdata <= '0;
    end else begin
      irqOut   <= lineHit;
      rspRdata <= rdNext;
    end
  end

  // R3
  pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqOut));
  // R3
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut != '0) |=> (irqOut == '0));
  // R4
  range_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.ring && !inRange |=> (irqOut == '0));
  // R8
  bad_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.bad |=> (irqOut == '0) && (rspRdata == '0));
endmodule

// File: rtl/msi_doorbell_frame.sv
module msi_doorbell_frame
  import msi_frame_pkg::*;
#(
  parameter int BASE_SPI  = 0,
  parameter int NUM_SPI   = 64,
  parameter int SPI_LIMIT = 128,
  parameter int ID_LIMIT  = 1020
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic               reqWrite,
  input  logic [11:0]        reqAddr,
  input  logic [31:0]        reqWdata,
  input  logic [2:0]         reqSize,
  output logic               rspValid,
  output logic [31:0]        rspRdata,
  output logic               rspErr,
  output logic [NUM_SPI-1:0] irqOut
);
  if (NUM_SPI < 1 || NUM_SPI > SPI_LIMIT) begin : g_bad_count
    $error("msi_doorbell_frame: NUM_SPI out of range");
  end
  if (BASE_SPI < 0 || BASE_SPI + 32 + NUM_SPI > ID_LIMIT) begin : g_bad_window
    $error("msi_doorbell_frame: interrupt window passes the ID limit");
  end

  frameStrobe_t strb;

  msi_frame_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqSize  (reqSize),
    .reqReady (reqReady),
    .strb     (strb),
    .rspValid (rspValid),
    .rspErr   (rspErr)
  );

  msi_frame_dp #(
    .BASE_SPI (BASE_SPI),
    .NUM_SPI  (NUM_SPI)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqWdata (reqWdata),
    .rspRdata (rspRdata),
    .irqOut   (irqOut)
  );
endmodule

// File: tb/msi_doorbell_frame_bench.sv
`timescale 1ns/1ps
module msi_doorbell_frame_bench;
  localparam int NSPI  = 64;
  localparam int FIRST = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [11:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic [2:0]  reqSize = '0;
  logic reqReady, rspValid, rspErr;
  logic [31:0] rspRdata;
  logic [NSPI-1:0] irqOut;

  always #2 clk = ~clk;

  msi_doorbell_frame u_msi_doorbell_frame (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqSize(reqSize), .rspValid(rspValid), .rspRdata(rspRdata),
    .rspErr(rspErr), .irqOut(irqOut)
  );

  typedef struct packed {
    logic [31:0]     rdata;
    logic            err;
    logic [NSPI-1:0] irq;
  } expItem_t;

  expItem_t expQ[$];
  string    tagQ[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Driver: pushes the expectation, then runs the handshake
  task automatic access(input bit wr, input logic [11:0] addr,
                        input logic [31:0] data, input logic [2:0] size,
                        input logic [31:0] expRd, input bit expErr,
                        input int expLine, input string tag);
    expItem_t it;
    it.rdata = expRd;
    it.err   = expErr;
    it.irq   = (expLine >= 0) ? (NSPI'(1) << expLine) : '0;
    expQ.push_back(it);
    tagQ.push_back(tag);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr;
    reqWdata = data; reqSize = size;
    @(negedge clk);
    check(reqReady === 1'b1, "R1", "ready after valid", 64'(reqReady), 64'd1);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // Monitor: compares each response against the queue head
  initial begin
    expItem_t e;
    string t;
    forever begin
      @(negedge clk);
      if (rstN && rspValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R1", "unexpected response", 64'd1, 64'd0);
        end else begin
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(rspRdata === e.rdata, t, "rdata", 64'(rspRdata), 64'(e.rdata));
          check(rspErr === e.err, t, "err", 64'(rspErr), 64'(e.err));
          check(irqOut === e.irq, t, "irq", 64'(irqOut), 64'(e.irq));
        end
      end else if (rstN) begin
        // R3 R10: lines low outside the response cycle
        check(irqOut === '0, "R10", "idle irq", 64'(irqOut), 64'd0);
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(reqReady === 1'b0 && rspValid === 1'b0 && irqOut === '0,
          "R1", "reset state", {62'd0, reqReady, rspValid}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    // R2 type register
    access(0, 12'h008, 0, 3'd4, 32'h0020_0040, 0, -1, "R2");
    // R3 window edges
    access(1, 12'h040, 32'd32, 3'd4, 0, 0, 0, "R3");
    access(1, 12'h040, 32'd95, 3'd4, 0, 0, NSPI-1, "R3");
    access(1, 12'h040, 32'd50, 3'd2, 0, 0, 50-FIRST, "R3");
    // R4 out of window
    access(1, 12'h040, 32'd31, 3'd4, 0, 0, -1, "R4");
    access(1, 12'h040, 32'd96, 3'd4, 0, 0, -1, "R4");
    access(1, 12'h040, 32'd0, 3'd2, 0, 0, -1, "R4");
    // R5 bad write sizes
    access(1, 12'h040, 32'd40, 3'd1, 0, 1, -1, "R5");
    access(1, 12'h040, 32'd40, 3'd3, 0, 1, -1, "R5");
    // R6 identification
    access(0, 12'hFCC, 0, 3'd4, 32'h0510_0000, 0, -1, "R6");
    // R7 zero space
    access(0, 12'hFD0, 0, 3'd4, 0, 0, -1, "R7");
    access(0, 12'hFE8, 0, 3'd4, 0, 0, -1, "R7");
    access(0, 12'hFFC, 0, 3'd4, 0, 0, -1, "R7");
    // R8 undefined or wrong direction
    access(0, 12'h000, 0, 3'd4, 0, 1, -1, "R8");
    access(0, 12'h040, 0, 3'd4, 0, 1, -1, "R8");
    access(1, 12'h008, 32'd40, 3'd4, 0, 1, -1, "R8");
    access(1, 12'hFD0, 32'd40, 3'd4, 0, 1, -1, "R8");
    access(1, 12'h044, 32'd40, 3'd4, 0, 1, -1, "R8");
    // R9 bad read sizes
    access(0, 12'h008, 0, 3'd2, 0, 1, -1, "R9");
    access(0, 12'hFCC, 0, 3'd1, 0, 1, -1, "R9");
    // R10 back to back same line
    access(1, 12'h040, 32'd50, 3'd4, 0, 0, 50-FIRST, "R10");
    access(1, 12'h040, 32'd50, 3'd4, 0, 0, 50-FIRST, "R10");
    // R11 upper data bits ignored
    access(1, 12'h040, 32'hFFFF_FC28, 3'd4, 0, 0, 40-FIRST, "R11");
    access(1, 12'h040, 32'hA5A5_0428, 3'd2, 0, 0, 40-FIRST, "R11");
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R1", "responses outstanding",
          64'(expQ.size()), 64'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule